// File: doc/BRIEF.md
# Quad-Rate Source-Synchronous Data Receiver

This block receives a 64-bit active-low data bus that carries four transfers in every period of the common clock. The bus is split into four 16-bit lanes. Each lane has its own pair of complementary strobes and its own active-low inversion flag. Each lane latches even-numbered beats on the falling edges of its P strobe and odd-numbered beats on the falling edges of its N strobe. As it latches a beat, the lane undoes the bus inversion: a lane whose inversion flag is asserted is taken as active high, and any other lane is taken as active low.

When a lane has latched its fourth beat, it freezes the whole transfer in a holding register and flips a toggle flag. A synchronizer in the common clock domain turns each flag change into a one-cycle event. The block waits until all four lanes have reported, so lanes may finish on slightly different strobe timing. It then assembles a 256-bit line and raises a one-cycle valid pulse. The data-ready indication (active low) is sampled together with beat 0 in every lane. A transfer that was not marked ready is consumed but never presented.

The holding registers are read in the clock domain only after the synchronizer has settled. For this reason, consecutive transfers must be at least four common-clock cycles apart from one completion to the next.

Top module: `qrx_top`

## Requirements
- R1: While reset is asserted and after it is released, `line_vld` is 0 and `line_data` is all zeros until a complete transfer arrives.
- R2: For a lane whose `bus_inv_n` bit is high (inactive), each received data bit is the inverse of the bus pin level.
- R3: For a lane whose `bus_inv_n` bit is low (active), the received bits equal the bus pin levels.
- R4: Beats 0 and 2 are latched on falling edges of `stb_p[g]`, and beats 1 and 3 on falling edges of `stb_n[g]`. Beat b of lane g lands in `line_data[64*b+16*g +: 16]`. Lane g uses bus bits `[16*g+15:16*g]`.
- R5: Each completed and ready transfer produces exactly one `line_vld` pulse, one cycle wide, within 8 clock cycles of the last strobe edge.
- R6: When `rdy_n` is high at the beat-0 edge of any lane, the transfer produces no `line_vld` pulse, and `line_data` keeps its previous value.
- R7: `line_data` changes only in a cycle where `line_vld` is 1.
- R8: A line is released only after all four lanes have completed their fourth beat, even when the lanes' strobes are skewed against each other.
- R9: Asserting reset in the middle of a transfer discards the partial beats. The next full transfer is then received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| bus_d_n | input | 64 | Active-low data pins, four 16-bit lanes |
| bus_inv_n | input | 4 | Active-low per-lane inversion flag |
| stb_p | input | 4 | Per-lane strobe for even beats (falling edge) |
| stb_n | input | 4 | Per-lane strobe for odd beats (falling edge) |
| rdy_n | input | 1 | Active-low data-ready, sampled with beat 0 |
| line_vld | output | 1 | One-cycle pulse: `line_data` holds a new line |
| line_data | output | 256 | Assembled line, beat 0 in the lowest 64 bits |

## Verification
The hardest condition to reach from the ports is the one where the four lanes finish at different times. One lane's completion event must then be held pending across clock edges while another lane is still latching beats. The stimulus reaches this by firing the strobes of each lane one after another with a per-lane delay, so the last lane finishes whole clock cycles after the first. A mid-transfer reset is also driven. It leaves the lane beat counters part-way through a transfer, and the check is that they restart at beat 0.

// File: rtl/qrx_pkg.sv
package qrx_pkg;
   // Bit offset of (beat, lane) inside the assembled line.
   function automatic int slot_lsb(input int beat, input int lane,
                                   input int lane_w, input int lanes);
      return (beat * lanes + lane) * lane_w;
   endfunction
endpackage

// File: rtl/qrx_tsync.sv
module qrx_tsync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgl_in,
   output logic evt
);
   if (STAGES < 2) begin : g_bad_stages
      $error("qrx_tsync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], tgl_in};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign evt = sync_q[STAGES-1] ^ last_q;

   // R5: a completion event never lasts two cycles
   assert_evt_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);
endmodule

// File: rtl/qrx_lane.sv
module qrx_lane #(
   parameter int LANE_W = 16,
   parameter int BEATS  = 4
) (
   input  logic                    rst_n,
   input  logic                    stb_p,
   input  logic                    stb_n,
   input  logic [LANE_W-1:0]       d_n,
   input  logic                    inv_n,
   input  logic                    rdy_n,
   output logic [BEATS*LANE_W-1:0] hold,
   output logic                    hold_rdy,
   output logic                    done_tgl
);
   localparam int HALF = BEATS / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

   if (BEATS < 4 || (BEATS % 2) != 0) begin : g_bad_beats
      $error("qrx_lane: BEATS must be even and at least 4");
   end

   // Undo bus inversion: inactive flag -> active-low pins, active flag -> as-is.
   logic [LANE_W-1:0] word;
   assign word = d_n ^ {LANE_W{inv_n}};

   logic [CW-1:0]              cnt_p, cnt_n;
   logic [HALF*LANE_W-1:0]     even_q;
   logic [(HALF-1)*LANE_W-1:0] odd_q;
   logic                       rdy_q;

   always_ff @(negedge stb_p or negedge rst_n) begin
      if (!rst_n) begin
         cnt_p  <= '0;
         even_q <= '0;
         rdy_q  <= 1'b0;
      end else begin
         even_q[int'(cnt_p)*LANE_W +: LANE_W] <= word;
         if (cnt_p == '0) rdy_q <= !rdy_n;
         cnt_p <= (int'(cnt_p) == HALF-1) ? '0 : cnt_p + 1'b1;
      end
   end

   always_ff @(negedge stb_n or negedge rst_n) begin
      if (!rst_n) begin
         cnt_n    <= '0;
         odd_q    <= '0;
         hold     <= '0;
         hold_rdy <= 1'b0;
         done_tgl <= 1'b0;
      end else if (int'(cnt_n) == HALF-1) begin
         for (int i = 0; i < HALF; i++)
            hold[(2*i)*LANE_W +: LANE_W] <= even_q[i*LANE_W +: LANE_W];
         for (int i = 0; i < HALF-1; i++)
            hold[(2*i+1)*LANE_W +: LANE_W] <= odd_q[i*LANE_W +: LANE_W];
         hold[(BEATS-1)*LANE_W +: LANE_W] <= word;
         hold_rdy <= rdy_q;
         done_tgl <= ~done_tgl;
         cnt_n    <= '0;
      end else begin
         odd_q[int'(cnt_n)*LANE_W +: LANE_W] <= word;
         cnt_n <= cnt_n + 1'b1;
      end
   end
endmodule

// File: rtl/qrx_top.sv
module qrx_top #(
   parameter int LANES       = 4,
   parameter int LANE_W      = 16,
   parameter int BEATS       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [LANES*LANE_W-1:0]          bus_d_n,
   input  logic [LANES-1:0]                 bus_inv_n,
   input  logic [LANES-1:0]                 stb_p,
   input  logic [LANES-1:0]                 stb_n,
   input  logic                             rdy_n,
   output logic                             line_vld,
   output logic [BEATS*LANES*LANE_W-1:0]    line_data
);
   import qrx_pkg::*;

   localparam int BUS_W  = LANES * LANE_W;
   localparam int LINE_W = BEATS * BUS_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("qrx_top: LANES must be at least 1");
   end

   logic [BEATS*LANE_W-1:0] lane_hold [LANES];
   logic [LANES-1:0]        lane_rdy, lane_tgl, done_evt;
   logic [LANES-1:0]        pend;
   logic [LINE_W-1:0]       line_asm;
   logic                    all_done;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      qrx_lane #(.LANE_W(LANE_W), .BEATS(BEATS)) lane_i (
         .rst_n    (rst_n),
         .stb_p    (stb_p[g]),
         .stb_n    (stb_n[g]),
         .d_n      (bus_d_n[g*LANE_W +: LANE_W]),
         .inv_n    (bus_inv_n[g]),
         .rdy_n    (rdy_n),
         .hold     (lane_hold[g]),
         .hold_rdy (lane_rdy[g]),
         .done_tgl (lane_tgl[g])
      );
      qrx_tsync #(.STAGES(SYNC_STAGES)) sync_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .tgl_in (lane_tgl[g]),
         .evt    (done_evt[g])
      );

      // R8: a lane's pending flag clears only when every lane has reported
      assert_release_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(pend[g]) |-> $past(&(pend | done_evt)));
   end

   always_comb begin
      line_asm = '0;
      for (int b = 0; b < BEATS; b++)
         for (int g = 0; g < LANES; g++)
            line_asm[slot_lsb(b, g, LANE_W, LANES) +: LANE_W] =
               lane_hold[g][b*LANE_W +: LANE_W];
   end

   assign all_done = &(pend | done_evt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= '0;
         line_vld  <= 1'b0;
         line_data <= '0;
      end else begin
         line_vld <= 1'b0;
         if (all_done) begin
            pend <= '0;
            if (&lane_rdy) begin
               line_vld  <= 1'b1;
               line_data <= line_asm;
            end
         end else begin
            pend <= pend | done_evt;
         end
      end
   end

   // R5: valid is a single-cycle pulse
   assert_vld_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      line_vld |=> !line_vld);

   // R7: the presented line moves only together with a valid pulse
   assert_line_moves_with_vld_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(line_data) |-> line_vld);

   // R6: a pulse needs a lane completion in the previous cycle
   assert_vld_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_vld) |-> $past(|done_evt));
endmodule

// File: tb/qrx_top_tb_top.sv
`timescale 1ns/1ps
module qrx_top_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [63:0]  bus_d_n = '1;
   logic [3:0]   bus_inv_n = '1;
   logic [3:0]   stb_p = '1;
   logic [3:0]   stb_n = '1;
   logic         rdy_n = 1'b1;
   logic         line_vld;
   logic [255:0] line_data;

   int checks = 0;
   int fails  = 0;
   int vld_cnt = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   qrx_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_d_n(bus_d_n), .bus_inv_n(bus_inv_n),
      .stb_p(stb_p), .stb_n(stb_n), .rdy_n(rdy_n),
      .line_vld(line_vld), .line_data(line_data)
   );

   always @(negedge clk) if (line_vld) vld_cnt++;

   // vector: seed[23:8] inv_n[7:4] rdy_n[3] skew[2:0]
   localparam logic [23:0] VEC [6] = '{
      {16'hA5C3, 4'b1111, 1'b0, 3'd0},
      {16'h1234, 4'b0000, 1'b0, 3'd0},
      {16'h0F0F, 4'b1010, 1'b0, 3'd0},
      {16'hFFFF, 4'b0101, 1'b0, 3'd6},
      {16'h7E81, 4'b1111, 1'b1, 3'd0},
      {16'h0001, 4'b0110, 1'b0, 3'd3}
   };

   function automatic logic [15:0] wd(input logic [15:0] seed, input int b, input int g);
      return seed ^ (16'(b * 4 + g) * 16'h0937);
   endfunction

   function automatic logic [255:0] exp_line(input logic [15:0] seed);
      logic [255:0] l;
      for (int b = 0; b < 4; b++)
         for (int g = 0; g < 4; g++)
            l[64*b + 16*g +: 16] = wd(seed, b, g);
      return l;
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive beats [0..nbeats-1]; lane g strobes g*skew ns after lane 0.
   task automatic send(input logic [15:0] seed, input logic [3:0] inv,
                       input logic rdy, input int skew, input int nbeats);
      bus_inv_n = inv;
      rdy_n = rdy;
      for (int b = 0; b < nbeats; b++) begin
         for (int g = 0; g < 4; g++)
            bus_d_n[16*g +: 16] = inv[g] ? ~wd(seed, b, g) : wd(seed, b, g);
         #1;
         for (int g = 0; g < 4; g++) begin
            if (b % 2 == 0) stb_p[g] = 1'b0; else stb_n[g] = 1'b0;
            #(skew);
         end
         #0.5;
         stb_p = '1;
         stb_n = '1;
         #0.5;
      end
   endtask

   task automatic settle();
      repeat (12) @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [255:0] last;
      int c0;
      repeat (4) @(negedge clk);
      chk(line_vld == 0 && line_data == '0, "R1 reset state", line_data, '0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(line_vld == 0 && line_data == '0, "R1 after release", line_data, '0);
      last = '0;

      // table walk: R2 R3 R4 R5 R6 R8
      for (int i = 0; i < 6; i++) begin
         logic [15:0] seed;
         logic [3:0]  inv;
         logic        rdy;
         int          skew;
         seed = VEC[i][23:8]; inv = VEC[i][7:4]; rdy = VEC[i][3]; skew = int'(VEC[i][2:0]);
         c0 = vld_cnt;
         send(seed, inv, rdy, skew, 4);
         settle();
         if (!rdy) begin
            last = exp_line(seed);
            chk(vld_cnt - c0 == 1, "R5 one pulse", 256'(vld_cnt - c0), 256'd1);
            chk(line_data == last, "R2 R3 R4 R8 line content", line_data, last);
         end else begin
            chk(vld_cnt == c0, "R6 no pulse when not ready", 256'(vld_cnt - c0), 256'd0);
            chk(line_data == last, "R6 R7 line kept", line_data, last);
         end
      end

      // R8: heavily skewed lanes, last lane finishes several clocks late
      c0 = vld_cnt;
      send(16'h5AA5, 4'b0011, 1'b0, 7, 4);
      settle();
      last = exp_line(16'h5AA5);
      chk(vld_cnt - c0 == 1, "R8 single pulse with skew", 256'(vld_cnt - c0), 256'd1);
      chk(line_data == last, "R8 skewed line", line_data, last);

      // R8: only three lanes complete -> nothing released yet
      c0 = vld_cnt;
      bus_inv_n = '1; rdy_n = 1'b0;
      for (int b = 0; b < 4; b++) begin
         bus_d_n = ~{4{wd(16'h3C3C, b, 0)}};
         #1;
         if (b % 2 == 0) stb_p[2:0] = 3'b000; else stb_n[2:0] = 3'b000;
         #1; stb_p = '1; stb_n = '1; #1;
      end
      settle();
      chk(vld_cnt == c0 && line_data == last, "R8 held while lane 3 pending", line_data, last);

      // R9: reset clears lane 3's partial state too, then a full transfer
      send(16'hDEAD, 4'b1111, 1'b0, 0, 2);
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(line_vld == 0 && line_data == '0, "R1 R9 reset mid transfer", line_data, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      c0 = vld_cnt;
      send(16'hBEEF, 4'b1001, 1'b0, 0, 4);
      settle();
      last = exp_line(16'hBEEF);
      chk(vld_cnt - c0 == 1, "R9 pulse after reset", 256'(vld_cnt - c0), 256'd1);
      chk(line_data == last, "R9 line after reset", line_data, last);

      // R6: a not-ready transfer right after a ready one keeps the line
      c0 = vld_cnt;
      send(16'h8421, 4'b0000, 1'b1, 0, 4);
      settle();
      chk(vld_cnt == c0 && line_data == last, "R6 R7 not-ready keeps line", line_data, last);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule